// File: doc/BRIEF.md
# Full/Empty Synchronizing Memory Bank

This block is one memory bank in which every word carries a full/empty tag, so that a producer thread and a consumer thread can hand a value across without locks or polling. Besides plain reads and writes it accepts two synchronizing operations. The first is a consuming load that waits for the word to be full and then empties it. The second is a producing store that waits for the word to be empty and then fills it. Every request names a return address. Each reply leaves the bank with the data and the address it must be delivered to. Thread registers live in memory, so that address is simply the register's memory location.

If a consuming load finds the word empty, nothing is returned. The bank writes the consumer's return address into the empty word and marks it as forwarding. When the matching producing store arrives, its data goes straight to that recorded address and the word drops back to plain empty. Anything beyond one waiting consumer and one producer is not resolved in hardware. The bank raises a handler event that carries the word index and the offending request, and leaves the word untouched. Requests are handled one per cycle, in order, and each reply or event is given in the cycle its request is accepted.

Top module: `fe_sync_bank`

## Requirements
- R1: While reset is high, req_ready is 0. After reset every word is empty (tag 0) with an all-zero payload, which is the plain-empty state, and resp_valid and trap_valid are 0.
- R2: A plain read (op 0) replies in the accepting cycle with the word's 64-bit payload on resp_data and its tag bit on resp_full. The state of the word does not change.
- R3: A plain write (op 1) stores req_wdata as the payload and req_wfull as the tag, whatever the word's prior state, including a forwarding state. It gives no reply and no event.
- R4: A consuming load (op 2) on a full word replies with the stored data, with resp_full 1. The word becomes empty with payload 0.
- R5: A consuming load on a plain-empty word gives no reply. The word stays empty and its payload becomes {req_ret[63:3], 1'b0, 2'b01}. State code 2'b01 in payload bits [1:0] means forwarding, and any other code on an empty word means plain empty.
- R6: A producing store (op 3) on a forwarding word replies with req_wdata and resp_full 1, addressed to the recorded target {payload[63:3], 3'b000}. The word becomes empty with payload 0.
- R7: A producing store on a plain-empty word gives no reply. The word becomes full and holds req_wdata.
- R8: A producing store on a full word raises trap_valid with trap_cause 1. The word is left unchanged and no reply is given.
- R9: A consuming load on a word that is already forwarding raises trap_valid with trap_cause 2. The word keeps its first recorded target.
- R10: Exactly one request is handled per accepted cycle. A reply and an event never occur in the same cycle. Neither occurs without req_valid. A request sees the results of the request accepted one cycle earlier.
- R11: Return addresses are 8-byte aligned register locations, that is, frame base plus register index times 8. Bits [2:0] of req_ret are ignored, and every resp_addr has bits [2:0] equal to 0.
- R12: Each trap reports the word index, opcode, return address and store data of the offending request on trap_idx, trap_op, trap_ret and trap_wdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank accepts a request this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 consuming load, 3 producing store |
| req_idx | input | ADDR_W | Word index within the bank |
| req_wdata | input | 64 | Data for writes and stores |
| req_wfull | input | 1 | Tag value for a plain write |
| req_ret | input | 64 | Requester's return byte address |
| resp_valid | output | 1 | Reply present |
| resp_addr | output | 64 | Delivery address of the reply |
| resp_data | output | 64 | Reply data |
| resp_full | output | 1 | Tag bit delivered with the data |
| trap_valid | output | 1 | Handler event present |
| trap_cause | output | 2 | 1 store to full word, 2 extra consumer |
| trap_op | output | 2 | Opcode of the offending request |
| trap_idx | output | ADDR_W | Word index of the offending request |
| trap_ret | output | 64 | Return address of the offending request |
| trap_wdata | output | 64 | Store data of the offending request |

## Verification
The assertions assume that req_op, req_idx and the data fields are stable and known whenever req_valid is high. They also assume that a reply is judged in the same cycle the request is accepted, because the outputs follow the request combinationally. The bench changes inputs only on the falling clock edge, lowers req_valid between scenarios, and waits for reset to finish before issuing any request. It uses only 8-byte aligned return addresses, except for the one case that checks that the low bits are dropped.

// File: rtl/fe_sync_pkg.sv
package fe_sync_pkg;

    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_WRITE    = 2'd1,
        OP_LOAD_FE  = 2'd2,
        OP_STORE_EF = 2'd3
    } fe_op_e;

    typedef enum logic [1:0] {
        TRAP_NONE           = 2'd0,
        TRAP_FULL_STORE     = 2'd1,
        TRAP_EXTRA_CONSUMER = 2'd2
    } trap_cause_e;

    localparam logic [1:0] CODE_PLAIN = 2'b00;
    localparam logic [1:0] CODE_FWD   = 2'b01;

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] payload;
    } tag_word_t;

    function automatic logic [DATA_W-1:0] align8(input logic [DATA_W-1:0] a);
        return {a[DATA_W-1:3], 3'b000};
    endfunction

    function automatic tag_word_t park_word(input logic [DATA_W-1:0] ret);
        tag_word_t w;
        w.full    = 1'b0;
        w.payload = {ret[DATA_W-1:3], 1'b0, CODE_FWD};
        return w;
    endfunction

    function automatic logic is_forwarding(input tag_word_t w);
        return !w.full && (w.payload[1:0] == CODE_FWD);
    endfunction

endpackage

// File: rtl/fe_word_store.sv
module fe_word_store
    import fe_sync_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_idx,
    output tag_word_t         rd_word,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  tag_word_t         wr_word
);
    localparam int DEPTH = 1 << ADDR_W;

    tag_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_word;
        end
    end

    assign rd_word = mem[rd_idx];

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_word)));

endmodule

// File: rtl/fe_tag_engine.sv
module fe_tag_engine
    import fe_sync_pkg::*;
(
    input  logic              acc,
    input  fe_op_e            op,
    input  tag_word_t         word,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wfull,
    input  logic [DATA_W-1:0] ret,
    output logic              we,
    output tag_word_t         new_word,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_addr,
    output logic [DATA_W-1:0] resp_data,
    output logic              resp_full,
    output logic              trap_valid,
    output trap_cause_e       trap_cause
);
    logic fwd;
    assign fwd = is_forwarding(word);

    always_comb begin
        we         = 1'b0;
        new_word   = word;
        resp_valid = 1'b0;
        resp_addr  = align8(ret);
        resp_data  = word.payload;
        resp_full  = word.full;
        trap_valid = 1'b0;
        trap_cause = TRAP_NONE;
        if (acc) begin
            case (op)
                OP_READ: begin
                    resp_valid = 1'b1;
                end
                OP_WRITE: begin
                    we            = 1'b1;
                    new_word.full    = wfull;
                    new_word.payload = wdata;
                end
                OP_LOAD_FE: begin
                    if (word.full) begin
                        resp_valid = 1'b1;
                        we         = 1'b1;
                        new_word   = '0;
                    end else if (fwd) begin
                        trap_valid = 1'b1;
                        trap_cause = TRAP_EXTRA_CONSUMER;
                    end else begin
                        we       = 1'b1;
                        new_word = park_word(ret);
                    end
                end
                OP_STORE_EF: begin
                    if (word.full) begin
                        trap_valid = 1'b1;
                        trap_cause = TRAP_FULL_STORE;
                    end else if (fwd) begin
                        resp_valid = 1'b1;
                        resp_addr  = align8(word.payload);
                        resp_data  = wdata;
                        resp_full  = 1'b1;
                        we         = 1'b1;
                        new_word   = '0;
                    end else begin
                        we               = 1'b1;
                        new_word.full    = 1'b1;
                        new_word.payload = wdata;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fe_sync_bank.sv
module fe_sync_bank
    import fe_sync_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_idx,
    input  logic [63:0]       req_wdata,
    input  logic              req_wfull,
    input  logic [63:0]       req_ret,
    output logic              resp_valid,
    output logic [63:0]       resp_addr,
    output logic [63:0]       resp_data,
    output logic              resp_full,
    output logic              trap_valid,
    output logic [1:0]        trap_cause,
    output logic [1:0]        trap_op,
    output logic [ADDR_W-1:0] trap_idx,
    output logic [63:0]       trap_ret,
    output logic [63:0]       trap_wdata
);
    logic        acc;
    fe_op_e      op;
    tag_word_t   rd_word;
    tag_word_t   new_word;
    logic        st_we;
    trap_cause_e cause;

    assign req_ready = !rst;
    assign acc       = req_valid && req_ready;
    assign op        = fe_op_e'(req_op);

    fe_word_store #(.ADDR_W(ADDR_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (req_idx),
        .rd_word (rd_word),
        .wr_en   (st_we),
        .wr_idx  (req_idx),
        .wr_word (new_word)
    );

    fe_tag_engine engine_i (
        .acc        (acc),
        .op         (op),
        .word       (rd_word),
        .wdata      (req_wdata),
        .wfull      (req_wfull),
        .ret        (req_ret),
        .we         (st_we),
        .new_word   (new_word),
        .resp_valid (resp_valid),
        .resp_addr  (resp_addr),
        .resp_data  (resp_data),
        .resp_full  (resp_full),
        .trap_valid (trap_valid),
        .trap_cause (cause)
    );

    assign trap_cause = cause;
    assign trap_op    = trap_valid ? req_op    : 2'd0;
    assign trap_idx   = trap_valid ? req_idx   : '0;
    assign trap_ret   = trap_valid ? req_ret   : '0;
    assign trap_wdata = trap_valid ? req_wdata : '0;

    // R10
    reply_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid || trap_valid) |-> req_valid);

    // R10
    reply_trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(resp_valid && trap_valid));

    // R4
    load_full_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && op == OP_LOAD_FE && rd_word.full)
        |-> (resp_valid && resp_data == rd_word.payload));

    // R6
    forward_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && op == OP_STORE_EF && is_forwarding(rd_word))
        |-> (resp_valid && resp_data == req_wdata));

    // R8
    full_store_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && op == OP_STORE_EF && rd_word.full)
        |-> (trap_valid && trap_cause == 2'd1 && !st_we));

    // R9
    extra_consumer_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && op == OP_LOAD_FE && is_forwarding(rd_word))
        |-> (trap_valid && trap_cause == 2'd2 && !st_we));

    // R11
    aligned_reply_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_addr[2:0] == 3'b000));

endmodule

// File: tb/fe_sync_bank_tb.sv
module fe_sync_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_idx = '0;
    logic [63:0]   req_wdata = '0;
    logic          req_wfull = 1'b0;
    logic [63:0]   req_ret = '0;
    logic          resp_valid;
    logic [63:0]   resp_addr;
    logic [63:0]   resp_data;
    logic          resp_full;
    logic          trap_valid;
    logic [1:0]    trap_cause;
    logic [1:0]    trap_op;
    logic [AW-1:0] trap_idx;
    logic [63:0]   trap_ret;
    logic [63:0]   trap_wdata;

    int n_run  = 0;
    int n_fail = 0;

    logic        s_rv, s_tv, s_rf;
    logic [63:0] s_ra, s_rd, s_tr, s_tw;
    logic [1:0]  s_tc, s_to;
    logic [AW-1:0] s_ti;

    always #(CLK_PERIOD/2) clk = ~clk;

    fe_sync_bank #(.ADDR_W(AW)) dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int idx, input logic [63:0] wd,
                         input logic wf, input logic [63:0] ret);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_idx = AW'(idx);
        req_wdata = wd; req_wfull = wf; req_ret = ret;
        #(CLK_PERIOD/4);
        s_rv = resp_valid; s_ra = resp_addr; s_rd = resp_data; s_rf = resp_full;
        s_tv = trap_valid; s_tc = trap_cause; s_to = trap_op; s_ti = trap_idx;
        s_tr = trap_ret;   s_tw = trap_wdata;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic read_word(input int idx, input string tag, input logic ef, input logic [63:0] ed);
        issue(2'd0, idx, 64'd0, 1'b0, 64'h80);
        chk(s_rv && !s_tv, {tag, " read reply"}, {63'd0, s_rv}, 64'd1);
        chk(s_rf == ef, {tag, " tag"}, {63'd0, s_rf}, {63'd0, ef});
        chk(s_rd == ed, {tag, " payload"}, s_rd, ed);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1 ready in reset", {63'd0, req_ready}, 64'd0);
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!resp_valid && !trap_valid, "R1 idle ports", {62'd0, resp_valid, trap_valid}, 64'd0);
        for (int i = 0; i < 3; i++) read_word(i, "R1 reset word", 1'b0, 64'd0);
        chk(s_ra == 64'h80, "R2 read addr", s_ra, 64'h80);
    endtask

    task automatic t_plain;
        issue(2'd1, 3, 64'hAAAA_0000_1234_5678, 1'b1, 64'h0);
        chk(!s_rv && !s_tv, "R3 write silent", {62'd0, s_rv, s_tv}, 64'd0);
        read_word(3, "R2 full read", 1'b1, 64'hAAAA_0000_1234_5678);
        read_word(3, "R2 read keeps", 1'b1, 64'hAAAA_0000_1234_5678);
        issue(2'd1, 3, 64'h55, 1'b0, 64'h0);
        read_word(3, "R3 empty write", 1'b0, 64'h55);
    endtask

    task automatic t_load_full;
        issue(2'd1, 4, 64'hBEEF, 1'b1, 64'h0);
        issue(2'd2, 4, 64'd0, 1'b0, 64'h2000);
        chk(s_rv && s_rd == 64'hBEEF && s_rf, "R4 load data", s_rd, 64'hBEEF);
        chk(s_ra == 64'h2000, "R4 load addr", s_ra, 64'h2000);
        read_word(4, "R4 emptied", 1'b0, 64'd0);
    endtask

    task automatic t_forward;
        issue(2'd2, 5, 64'd0, 1'b0, 64'h1000 + 5*8 + 3);
        chk(!s_rv && !s_tv, "R5 park silent", {62'd0, s_rv, s_tv}, 64'd0);
        read_word(5, "R5 parked", 1'b0, 64'h1029);
        issue(2'd3, 5, 64'hCAFE_F00D, 1'b0, 64'h3000);
        chk(s_rv && s_rd == 64'hCAFE_F00D && s_rf, "R6 forward data", s_rd, 64'hCAFE_F00D);
        chk(s_ra == 64'h1028, "R11 forward target", s_ra, 64'h1028);
        read_word(5, "R6 back to empty", 1'b0, 64'd0);
    endtask

    task automatic t_store;
        issue(2'd3, 6, 64'h7777, 1'b0, 64'h0);
        chk(!s_rv && !s_tv, "R7 store silent", {62'd0, s_rv, s_tv}, 64'd0);
        read_word(6, "R7 filled", 1'b1, 64'h7777);
        issue(2'd3, 6, 64'h9999, 1'b0, 64'h4008);
        chk(s_tv && !s_rv && s_tc == 2'd1, "R8 trap cause", {62'd0, s_tc}, 64'd1);
        chk(s_ti == AW'(6) && s_to == 2'd3, "R12 trap idx/op", {58'd0, s_to, s_ti}, {58'd0, 2'd3, AW'(6)});
        chk(s_tr == 64'h4008 && s_tw == 64'h9999, "R12 trap ret/data", s_tw, 64'h9999);
        read_word(6, "R8 unchanged", 1'b1, 64'h7777);
    endtask

    task automatic t_second_consumer;
        issue(2'd2, 7, 64'd0, 1'b0, 64'h5000);
        issue(2'd2, 7, 64'd0, 1'b0, 64'h6000);
        chk(s_tv && !s_rv && s_tc == 2'd2, "R9 trap cause", {62'd0, s_tc}, 64'd2);
        chk(s_tr == 64'h6000, "R12 trap ret", s_tr, 64'h6000);
        issue(2'd3, 7, 64'h1111, 1'b0, 64'h0);
        chk(s_rv && s_ra == 64'h5000, "R9 first target kept", s_ra, 64'h5000);
    endtask

    task automatic t_order;
        @(negedge clk);
        chk(!resp_valid && !trap_valid, "R10 idle without valid", {62'd0, resp_valid, trap_valid}, 64'd0);
        issue(2'd3, 9, 64'h4242, 1'b0, 64'h0);
        issue(2'd2, 9, 64'd0, 1'b0, 64'h7000);
        chk(s_rv && s_rd == 64'h4242, "R10 back-to-back", s_rd, 64'h4242);
        issue(2'd2, 8, 64'd0, 1'b0, 64'h7100);
        issue(2'd1, 8, 64'd0, 1'b0, 64'h0);
        issue(2'd3, 8, 64'h88, 1'b0, 64'h0);
        chk(!s_rv && !s_tv, "R3 write cleared forwarding", {62'd0, s_rv, s_tv}, 64'd0);
        read_word(8, "R3 then stored", 1'b1, 64'h88);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_load_full();
        t_forward();
        t_store();
        t_second_consumer();
        t_order();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule